// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block holds the interrupt enable register and produces the interrupt identification value of a 16550-style serial port. A byte-wide register port is split into a read side and a write side. Both carry a register offset, and a divisor-latch access input decides whether offsets 0 and 1 reach the divisor bytes or the normal registers. The rest of the UART supplies its status as plain inputs: the line status error bits, a receive-data-available flag, the modem status delta bits and the FIFO enable bit. From these inputs the block ranks the pending causes and reports the winner. It also drives a single interrupt request line.

Three causes are evaluated live from the status inputs on every cycle: line status, receive and modem. The transmitter-empty cause is different, because a sticky flag holds it. That flag is managed by a two-state machine with the states THRE_CLEAR and THRE_ARMED. Reset enters THRE_ARMED. The transition CLEAR_ON_REPORT moves to THRE_CLEAR when an identification read reports the transmitter-empty cause. The transition REARM_ON_ENABLE moves to THRE_ARMED when the enable register is written with the transmitter-empty enable bit set while that bit is already set. When both events happen in the same cycle, REARM_ON_ENABLE takes precedence. In every other case the state holds (HOLD).

Top module: `uart_intid`

## Requirements
- R1: Causes rank line status (highest), then receive, then transmitter empty, then modem (lowest). The identification register reports the highest-ranked enabled active cause in bits 3:1, with bit 0 at 0. The codes are 3'b011 for line status, 3'b010 for receive, 3'b001 for transmitter empty and 3'b000 for modem, so bits 3:0 read 0x6, 0x4, 0x2 and 0x0 respectively.
- R2: A cause is reported only when its enable bit is set. The enable bits are: bit 0 receive, bit 1 transmitter empty, bit 2 line status, bit 3 modem. Line status is active when any line error bit is set, receive when the receive flag is high, and modem when any delta bit is set.
- R3: When no enabled cause is active, identification bits 3:0 read 4'b0001.
- R4: Identification bits 7:6 read 2'b11 when the FIFO enable input is high and 2'b00 otherwise. Bits 5:4 always read 0.
- R5: A read of the identification register (offset 2) that reports the transmitter-empty code clears the sticky transmitter-empty flag. A read of that register that reports any other code leaves the flag unchanged.
- R6: A write to the enable register (offset 1, divisor-latch access bit low) that has bit 1 set, while bit 1 is already set, sets the sticky flag again. A write that sets bit 1 when it was previously clear does not set the flag.
- R7: Enable register writes keep only bits 3:0. Bits 7:4 read back as 0.
- R8: After reset, the enable register is 0, the interrupt line is low and the sticky transmitter-empty flag is set.
- R9: With the divisor-latch access bit high, offsets 0 and 1 write and read the divisor low and high bytes, and the enable register is unchanged.
- R10: The interrupt output is high exactly when some enabled cause is active. It follows the inputs in the same cycle.
- R11: If a clearing identification read and a re-arming enable write fall in the same cycle, the sticky flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe (side effects only; read data is always driven) |
| rd_addr | input | 3 | Read register offset |
| rd_data | output | 8 | Read data for rd_addr, combinational |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register offset |
| wr_data | input | 8 | Write data |
| div_access | input | 1 | Divisor-latch access bit |
| fifo_on | input | 1 | FIFO control enable bit |
| line_err | input | 4 | Line status error bits |
| rx_ready | input | 1 | Receive FIFO not empty |
| modem_delta | input | 4 | Modem status delta bits |
| irq | output | 1 | Interrupt request |

## Verification
The flag clear caused by an identification read and the flag re-arm caused by an enable write can occur in the same clock cycle. The bench provokes this by asserting both strobes together: a read at offset 2 that currently reports the transmitter-empty code, and a write of bit 1 to the enable register while that bit is already set. The result is judged after the edge by reading the identification value again. It must still report the transmitter-empty code with the interrupt line high. The same run also checks that a read reporting a higher-ranked cause does not clear the flag.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;
    localparam int ADDR_W     = 3;
    localparam int DATA_W     = 8;
    localparam int NUM_CAUSES = 4;
    localparam int IER_W      = NUM_CAUSES;

    localparam logic [ADDR_W-1:0] OFS_LO = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_HI = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ID = 3'd2;

    // cause index equals priority rank, 0 is highest
    localparam int IDX_LINE  = 0;
    localparam int IDX_RX    = 1;
    localparam int IDX_TX    = 2;
    localparam int IDX_MODEM = 3;

    typedef enum logic {
        THRE_CLEAR = 1'b0,
        THRE_ARMED = 1'b1
    } thre_state_e;

    // enable register bit position owned by each cause
    function automatic int en_bit(input int idx);
        case (idx)
            IDX_LINE:  en_bit = 2;
            IDX_RX:    en_bit = 0;
            IDX_TX:    en_bit = 1;
            default:   en_bit = 3;
        endcase
    endfunction

    // identification code: highest rank carries the largest code
    function automatic logic [2:0] code_of(input int idx);
        code_of = 3'(NUM_CAUSES - 1 - idx);
    endfunction
endpackage

// File: rtl/uart_intid_regs.sv
module uart_intid_regs
    import uart_intid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              div_access,
    output logic [IER_W-1:0]  ier,
    output logic [DATA_W-1:0] div_lo,
    output logic [DATA_W-1:0] div_hi,
    output logic              rearm
);
    localparam int TXB = en_bit(IDX_TX);

    logic wr_ier, wr_lo_div, wr_hi_div;

    assign wr_ier    = wr_en && !div_access && (wr_addr == OFS_HI);
    assign wr_lo_div = wr_en &&  div_access && (wr_addr == OFS_LO);
    assign wr_hi_div = wr_en &&  div_access && (wr_addr == OFS_HI);

    // re-arm uses the enable bit as stored before this write
    assign rearm = wr_ier && wr_data[TXB] && ier[TXB];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier    <= '0;
            div_lo <= '0;
            div_hi <= '0;
        end else begin
            if (wr_ier)    ier    <= wr_data[IER_W-1:0];
            if (wr_lo_div) div_lo <= wr_data;
            if (wr_hi_div) div_hi <= wr_data;
        end
    end
endmodule

// File: rtl/uart_intid_thre.sv
module uart_intid_thre
    import uart_intid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    input  logic set_req,
    output logic armed
);
    thre_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= THRE_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            THRE_ARMED: if (clr_req && !set_req) state_d = THRE_CLEAR; // CLEAR_ON_REPORT
            THRE_CLEAR: if (set_req)             state_d = THRE_ARMED; // REARM_ON_ENABLE
            default:                             state_d = THRE_ARMED;
        endcase
    end

    always_comb begin
        armed = (state_q == THRE_ARMED);
    end
endmodule

// File: rtl/uart_intid_arb.sv
module uart_intid_arb
    import uart_intid_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] cond,
    input  logic [IER_W-1:0]      ier,
    input  logic                  fifo_on,
    output logic [DATA_W-1:0]     iir,
    output logic                  pending,
    output logic                  tx_shown
);
    logic [NUM_CAUSES-1:0] hit;

    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_hit
        assign hit[g] = cond[g] & ier[en_bit(g)];
    end

    logic       found;
    logic [2:0] code;
    int         win;

    always_comb begin
        found = 1'b0;
        win   = 0;
        for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                win   = i;
            end
        end
        code = found ? code_of(win) : 3'b000;
    end

    assign pending  = found;
    assign tx_shown = found && (win == IDX_TX);
    assign iir      = {{2{fifo_on}}, 2'b00, code, ~found};
endmodule

// File: rtl/uart_intid.sv
module uart_intid
    import uart_intid_pkg::*;
#(
    parameter int LINE_W  = 4,
    parameter int MODEM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [2:0]         rd_addr,
    output logic [7:0]         rd_data,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               div_access,
    input  logic               fifo_on,
    input  logic [LINE_W-1:0]  line_err,
    input  logic               rx_ready,
    input  logic [MODEM_W-1:0] modem_delta,
    output logic               irq
);
    logic [IER_W-1:0]      ier_val;
    logic [DATA_W-1:0]     div_lo, div_hi, iir;
    logic                  rearm, thre_armed, tx_shown, pending, clr_req;
    logic [NUM_CAUSES-1:0] cond;

    uart_intid_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_access(div_access), .ier(ier_val),
        .div_lo(div_lo), .div_hi(div_hi), .rearm(rearm)
    );

    always_comb begin
        cond            = '0;
        cond[IDX_LINE]  = |line_err;
        cond[IDX_RX]    = rx_ready;
        cond[IDX_TX]    = thre_armed;
        cond[IDX_MODEM] = |modem_delta;
    end

    uart_intid_arb u_arb (
        .cond(cond), .ier(ier_val), .fifo_on(fifo_on),
        .iir(iir), .pending(pending), .tx_shown(tx_shown)
    );

    assign clr_req = rd_en && (rd_addr == OFS_ID) && tx_shown;

    uart_intid_thre u_thre (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req),
        .set_req(rearm), .armed(thre_armed)
    );

    assign irq = pending;

    always_comb begin
        unique case (rd_addr)
            OFS_LO:  rd_data = div_access ? div_lo : '0;
            OFS_HI:  rd_data = div_access ? div_hi : {{(DATA_W-IER_W){1'b0}}, ier_val};
            OFS_ID:  rd_data = iir;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/uart_intid_check.sv
module uart_intid_check
    import uart_intid_pkg::*;
#(
    parameter int LINE_W  = 4,
    parameter int MODEM_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [2:0]         rd_addr,
    input logic [7:0]         rd_data,
    input logic               wr_en,
    input logic [2:0]         wr_addr,
    input logic [7:0]         wr_data,
    input logic               div_access,
    input logic               fifo_on,
    input logic [LINE_W-1:0]  line_err,
    input logic               rx_ready,
    input logic [MODEM_W-1:0] modem_delta,
    input logic               irq,
    input logic               thre_armed,
    input logic [IER_W-1:0]   ier_val
);
    logic rearm_wr, clear_rd;
    assign rearm_wr = wr_en && !div_access && (wr_addr == OFS_HI) && wr_data[1] && ier_val[1];
    assign clear_rd = rd_en && (rd_addr == OFS_ID) && (rd_data[3:0] == 4'b0010);

    assert_line_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr == OFS_ID) && (|line_err) && ier_val[2]) |-> (rd_data[3:0] == 4'b0110));

    assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr == OFS_ID) && (ier_val == '0)) |-> (rd_data[3:0] == 4'b0001));

    assert_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr == OFS_ID) && !irq) |-> (rd_data[3:0] == 4'b0001));

    assert_fifo_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == OFS_ID) |-> (rd_data[7:4] == {{2{fifo_on}}, 2'b00}));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_rd && !rearm_wr) |=> !thre_armed);

    assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_wr |=> thre_armed);

    assert_ier_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr == OFS_HI) && !div_access) |-> (rd_data[7:4] == 4'h0));

    assert_irq_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((|line_err && ier_val[2]) || (rx_ready && ier_val[0]) ||
                (thre_armed && ier_val[1]) || (|modem_delta && ier_val[3])));

    assert_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_rd && rearm_wr) |=> thre_armed);
endmodule

bind uart_intid uart_intid_check #(.LINE_W(LINE_W), .MODEM_W(MODEM_W)) u_check (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .div_access(div_access),
    .fifo_on(fifo_on), .line_err(line_err), .rx_ready(rx_ready),
    .modem_delta(modem_delta), .irq(irq), .thre_armed(thre_armed), .ier_val(ier_val)
);

// File: tb/uart_intid_test.sv
`timescale 1ns/1ps
module uart_intid_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0] rd_addr = 3'd0, wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       div_access = 1'b0, fifo_on = 1'b0, rx_ready = 1'b0;
    logic [3:0] line_err = 4'h0, modem_delta = 4'h0;
    logic       irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    uart_intid uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .div_access(div_access),
        .fifo_on(fifo_on), .line_err(line_err), .rx_ready(rx_ready),
        .modem_delta(modem_delta), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a; rd_en = 1'b1;
        #1;
        v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_iir(input string req, input logic [7:0] exp, input logic exp_irq);
        logic [7:0] v;
        peek(3'd2, v);
        chk(req, "iir", v, exp);
        chk("R10", "irq", {7'b0, irq}, {7'b0, exp_irq});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        expect_iir("R8", 8'h01, 1'b0);
        peek(3'd1, v);
        chk("R8", "ier after reset", v, 8'h00);
        wr(3'd1, 8'h02);
        expect_iir("R8", 8'h02, 1'b1);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        rd(3'd2, v);
        chk("R5", "reported code", v, 8'h02);
        expect_iir("R5", 8'h01, 1'b0);
    endtask

    task automatic t_rearm;
        logic [7:0] v;
        wr(3'd1, 8'h02);
        expect_iir("R6", 8'h02, 1'b1);
        rd(3'd2, v);
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h02);
        expect_iir("R6", 8'h01, 1'b0);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        wr(3'd1, 8'h0F);
        @(negedge clk);
        line_err = 4'h4; rx_ready = 1'b1; modem_delta = 4'h2;
        expect_iir("R1", 8'h06, 1'b1);
        rd(3'd2, v);
        chk("R5", "line read", v, 8'h06);
        line_err = 4'h0;
        expect_iir("R1", 8'h04, 1'b1);
        rx_ready = 1'b0;
        expect_iir("R5", 8'h02, 1'b1);
        rd(3'd2, v);
        expect_iir("R1", 8'h00, 1'b1);
        modem_delta = 4'h0;
        expect_iir("R3", 8'h01, 1'b0);
    endtask

    task automatic t_gating;
        wr(3'd1, 8'h00);
        line_err = 4'h1; rx_ready = 1'b1; modem_delta = 4'h8;
        expect_iir("R2", 8'h01, 1'b0);
        wr(3'd1, 8'h08);
        expect_iir("R2", 8'h00, 1'b1);
        wr(3'd1, 8'h01);
        expect_iir("R2", 8'h04, 1'b1);
        line_err = 4'h0; rx_ready = 1'b0; modem_delta = 4'h0;
        expect_iir("R3", 8'h01, 1'b0);
    endtask

    task automatic t_fifo;
        fifo_on = 1'b1;
        expect_iir("R4", 8'hC1, 1'b0);
        rx_ready = 1'b1;
        expect_iir("R4", 8'hC4, 1'b1);
        rx_ready = 1'b0; fifo_on = 1'b0;
        expect_iir("R4", 8'h01, 1'b0);
    endtask

    task automatic t_upper;
        logic [7:0] v;
        wr(3'd1, 8'hF5);
        peek(3'd1, v);
        chk("R7", "ier readback", v, 8'h05);
    endtask

    task automatic t_divisor;
        logic [7:0] v;
        @(negedge clk);
        div_access = 1'b1;
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        peek(3'd0, v);
        chk("R9", "divisor low", v, 8'h34);
        peek(3'd1, v);
        chk("R9", "divisor high", v, 8'h12);
        div_access = 1'b0;
        peek(3'd1, v);
        chk("R9", "ier kept", v, 8'h05);
        peek(3'd0, v);
        chk("R9", "offset 0 plain", v, 8'h00);
    endtask

    task automatic t_both;
        logic [7:0] v;
        wr(3'd1, 8'h02);
        wr(3'd1, 8'h02);
        expect_iir("R11", 8'h02, 1'b1);
        @(negedge clk);
        rd_addr = 3'd2; rd_en = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h02;
        #1;
        v = rd_data;
        chk("R11", "reported code", v, 8'h02);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        expect_iir("R11", 8'h02, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clear();
        t_rearm();
        t_priority();
        t_gating();
        t_fifo();
        t_upper();
        t_divisor();
        t_both();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule